// File: doc/BRIEF.md
# Serial Register-Access Port with Mode Entry

This block is the slave end of a four-wire serial control link into an 8-bit register file addressed by 8-bit subaddresses. The select pin is shared with another function, so after reset the port stays silent and only counts pulses on that pin. The third rising edge of select switches the port into serial mode. Once in serial mode it stays there until reset.

In serial mode each transaction is framed by select going low and then high again. The first byte is a command: 0xD4 selects a write and 0xD5 selects a read. A write frame carries a starting subaddress and then any number of data bytes, which land in ascending registers. A read frame continues from the subaddress left by the latest write frame and returns register bytes on the master-in line. All pins are sampled by the system clock through two-flop synchronizers. The system clock must run at least four times as fast as the serial clock.

The state machine has seven states. `ST_OFF` moves to `ST_IDLE` when mode entry fires. `ST_IDLE` moves to `ST_CMD` on a select fall. When the command byte completes, `ST_CMD` moves to `ST_ADDR` on the write code, to `ST_RDATA` on the read code, and to `ST_SKIP` on any other value. `ST_ADDR` moves to `ST_WDATA` once the subaddress byte is complete. From every state inside a frame, a high select returns the machine to `ST_IDLE`.

Top module: `spi_regport`

## Requirements
- R1: Before the third rising edge of select after reset, `miso_o` is 0 and no register write occurs, whatever SCLK and MOSI do. `spi_mode_o` rises after that third edge.
- R2: Once `spi_mode_o` is 1 it stays 1 until reset.
- R3: A frame starts when select falls and ends when select rises. MOSI bits are taken on SCLK rising edges, most significant bit first.
- R4: In a frame whose command is 0xD4, the second byte sets the subaddress and each later complete byte is written to the register at the current subaddress.
- R5: After each written byte the subaddress increases by one, wrapping from 0xFF to 0x00. A frame with one data byte changes only that one register.
- R6: A data byte is written only once all 8 bits have arrived. A byte cut short by select rising writes nothing.
- R7: In a frame whose command is 0xD5, `miso_o` shifts out the registers from the current subaddress upward, most significant bit first, changing after SCLK falling edges.
- R8: A command byte other than 0xD4 or 0xD5 makes the rest of the frame inert: no register is written and `miso_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x SCLK |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from master |
| sel_i | input | 1 | Shared select pin, active low in serial mode |
| mosi_i | input | 1 | Serial data from master |
| miso_o | output | 1 | Serial data to master |
| spi_mode_o | output | 1 | High once serial mode has been entered |
| rf_we_o | output | 1 | One-cycle register write strobe |
| rf_addr_o | output | 8 | Register subaddress for both write and read |
| rf_wdata_o | output | 8 | Register write data |
| rf_rdata_i | input | 8 | Register read data at `rf_addr_o`, combinational |

## Verification
Two events can fall on the same system clock. The first is the completion of a byte on an SCLK rising edge. The second is a select rise that closes the frame. The bench provokes this by ending frames partway through a byte, and by ending them right after the eighth bit. It judges the result by checking that the partial byte leaves its register unchanged while the complete byte before it is kept. The second pair is the prefetch load of the next read byte and the subaddress increment on an SCLK fall. The bench judges these by comparing whole read bursts, including bursts that cross from 0xFF to 0x00, against its own register model.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_WDATA,
        ST_RDATA,
        ST_SKIP
    } frame_state_t;

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int               N        = 1,
    parameter int               STAGES   = 2,
    parameter logic [N-1:0]     RST_VAL  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] q_o
);

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= {STAGES{RST_VAL[g]}};
                end else begin
                    chain <= {chain[STAGES-2:0], d_i[g]};
                end
            end
            assign q_o[g] = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/spi_edge.sv
module spi_edge #(
    parameter int           N       = 1,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] q_i,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);

    logic [N-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= RST_VAL;
        end else begin
            prev_q <= q_i;
        end
    end

    assign rise_o = q_i & ~prev_q;
    assign fall_o = ~q_i & prev_q;

endmodule

// File: rtl/spi_mode_entry.sv
module spi_mode_entry #(
    parameter int PULSES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_rise_i,
    output logic mode_o
);

    localparam int CW = $clog2(PULSES + 1);
    localparam logic [CW-1:0] LAST = CW'(PULSES - 1);

    logic [CW-1:0] pulse_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_cnt <= '0;
            mode_o    <= 1'b0;
        end else if (!mode_o && sel_rise_i) begin
            if (pulse_cnt == LAST) begin
                mode_o <= 1'b1;
            end else begin
                pulse_cnt <= pulse_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
    import spi_regport_pkg::*;
#(
    parameter int               DATA_W = 8,
    parameter int               ADDR_W = 8,
    parameter logic [DATA_W-1:0] CMD_WR = 8'hD4,
    parameter logic [DATA_W-1:0] CMD_RD = 8'hD5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_i,
    input  logic              sel_s_i,
    input  logic              sel_fall_i,
    input  logic              sclk_rise_i,
    input  logic              sclk_fall_i,
    input  logic              mosi_s_i,
    input  logic [DATA_W-1:0] rf_rdata_i,
    output logic              miso_o,
    output logic              rf_we_o,
    output logic [ADDR_W-1:0] rf_addr_o,
    output logic [DATA_W-1:0] rf_wdata_o
);

    localparam int BW = $clog2(DATA_W);
    localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

    frame_state_t state_q, state_n;

    logic [BW-1:0]     bit_cnt;
    logic [DATA_W-1:0] rx_sh;
    logic [DATA_W-1:0] tx_sh;
    logic [DATA_W-1:0] rx_byte;
    logic [ADDR_W-1:0] addr_q;
    logic              load_pend;
    logic              we_q;
    logic [DATA_W-1:0] wdata_q;
    logic              byte_done;
    logic              in_frame;

    assign rx_byte   = {rx_sh[DATA_W-2:0], mosi_s_i};
    assign byte_done = sclk_rise_i && (bit_cnt == LAST_BIT);
    assign in_frame  = (state_q != ST_OFF) && (state_q != ST_IDLE);

    // next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (mode_i) state_n = ST_IDLE;
            end
            ST_IDLE: begin
                if (sel_fall_i) state_n = ST_CMD;
            end
            ST_CMD: begin
                if (sel_s_i) begin
                    state_n = ST_IDLE;
                end else if (byte_done) begin
                    if (rx_byte == CMD_WR)      state_n = ST_ADDR;
                    else if (rx_byte == CMD_RD) state_n = ST_RDATA;
                    else                        state_n = ST_SKIP;
                end
            end
            ST_ADDR: begin
                if (sel_s_i)        state_n = ST_IDLE;
                else if (byte_done) state_n = ST_WDATA;
            end
            ST_WDATA, ST_RDATA, ST_SKIP: begin
                if (sel_s_i) state_n = ST_IDLE;
            end
            default: state_n = ST_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_n;
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            addr_q    <= '0;
            load_pend <= 1'b0;
            we_q      <= 1'b0;
            wdata_q   <= '0;
        end else begin
            we_q <= 1'b0;
            if (we_q) begin
                addr_q <= addr_q + 1'b1;
            end
            if (!in_frame || sel_s_i) begin
                bit_cnt   <= '0;
                rx_sh     <= '0;
                tx_sh     <= '0;
                load_pend <= 1'b0;
            end else begin
                if (sclk_rise_i) begin
                    bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
                    rx_sh   <= rx_byte;
                end
                unique case (state_q)
                    ST_CMD: begin
                        if (byte_done && rx_byte == CMD_RD) load_pend <= 1'b1;
                    end
                    ST_ADDR: begin
                        if (byte_done) addr_q <= rx_byte[ADDR_W-1:0];
                    end
                    ST_WDATA: begin
                        if (byte_done) begin
                            we_q    <= 1'b1;
                            wdata_q <= rx_byte;
                        end
                    end
                    ST_RDATA: begin
                        if (byte_done) load_pend <= 1'b1;
                        if (sclk_fall_i) begin
                            if (load_pend) begin
                                tx_sh     <= rf_rdata_i;
                                addr_q    <= addr_q + 1'b1;
                                load_pend <= 1'b0;
                            end else begin
                                tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign miso_o     = (state_q == ST_RDATA) ? tx_sh[DATA_W-1] : 1'b0;
    assign rf_we_o    = we_q;
    assign rf_addr_o  = addr_q;
    assign rf_wdata_o = wdata_q;

endmodule

// File: rtl/spi_regport.sv
module spi_regport #(
    parameter int               DATA_W      = 8,
    parameter int               ADDR_W      = 8,
    parameter int               SYNC_STAGES = 2,
    parameter int               ENTRY_PULSES = 3,
    parameter logic [DATA_W-1:0] CMD_WR     = 8'hD4,
    parameter logic [DATA_W-1:0] CMD_RD     = 8'hD5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              sel_i,
    input  logic              mosi_i,
    output logic              miso_o,
    output logic              spi_mode_o,
    output logic              rf_we_o,
    output logic [ADDR_W-1:0] rf_addr_o,
    output logic [DATA_W-1:0] rf_wdata_o,
    input  logic [DATA_W-1:0] rf_rdata_i
);

    // bit order: [2]=mosi, [1]=sel, [0]=sclk
    logic [2:0] pins_s;
    logic [1:0] edge_rise, edge_fall;

    spi_sync #(
        .N       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({mosi_i, sel_i, sclk_i}),
        .q_o   (pins_s)
    );

    spi_edge #(
        .N       (2),
        .RST_VAL (2'b10)
    ) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .q_i    (pins_s[1:0]),
        .rise_o (edge_rise),
        .fall_o (edge_fall)
    );

    spi_mode_entry #(
        .PULSES (ENTRY_PULSES)
    ) u_entry (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_rise_i (edge_rise[1]),
        .mode_o     (spi_mode_o)
    );

    spi_frame_engine #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .CMD_WR (CMD_WR),
        .CMD_RD (CMD_RD)
    ) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (spi_mode_o),
        .sel_s_i     (pins_s[1]),
        .sel_fall_i  (edge_fall[1]),
        .sclk_rise_i (edge_rise[0]),
        .sclk_fall_i (edge_fall[0]),
        .mosi_s_i    (pins_s[2]),
        .rf_rdata_i  (rf_rdata_i),
        .miso_o      (miso_o),
        .rf_we_o     (rf_we_o),
        .rf_addr_o   (rf_addr_o),
        .rf_wdata_o  (rf_wdata_o)
    );

endmodule

// File: rtl/spi_regport_chk.sv
module spi_regport_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              miso_o,
    input logic              spi_mode_o,
    input logic              rf_we_o,
    input logic [ADDR_W-1:0] rf_addr_o
);

    // R1: silent until mode entry
    a_r1_quiet_before_entry: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_mode_o |-> (!miso_o && !rf_we_o));

    // R2: mode is sticky
    a_r2_mode_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        spi_mode_o |=> spi_mode_o);

    // R5: subaddress advances after a write
    a_r5_incr_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we_o |=> (rf_addr_o == ADDR_W'($past(rf_addr_o) + 1'b1)));

    // R6: one strobe per complete byte
    a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we_o |=> !rf_we_o);

    // R8: write activity never drives the return line
    a_r8_miso_low_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we_o |-> !miso_o);

endmodule

bind spi_regport spi_regport_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .miso_o     (miso_o),
    .spi_mode_o (spi_mode_o),
    .rf_we_o    (rf_we_o),
    .rf_addr_o  (rf_addr_o)
);

// File: tb/sim_spi_regport.sv
`timescale 1ns/1ps
module sim_spi_regport;

    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0;
    logic       sel = 1'b1;
    logic       mosi = 1'b0;
    logic       miso_o;
    logic       spi_mode_o;
    logic       rf_we_o;
    logic [7:0] rf_addr_o;
    logic [7:0] rf_wdata_o;
    logic [7:0] rf_rdata_i;

    logic [7:0] regs [256];
    logic [7:0] exp_regs [256];

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    spi_regport u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_i     (sclk),
        .sel_i      (sel),
        .mosi_i     (mosi),
        .miso_o     (miso_o),
        .spi_mode_o (spi_mode_o),
        .rf_we_o    (rf_we_o),
        .rf_addr_o  (rf_addr_o),
        .rf_wdata_o (rf_wdata_o),
        .rf_rdata_i (rf_rdata_i)
    );

    // register file driven by the design
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) regs[i] <= 8'(i) ^ 8'h5A;
        end else if (rf_we_o) begin
            regs[rf_addr_o] <= rf_wdata_o;
        end
    end
    assign rf_rdata_i = regs[rf_addr_o];

    function automatic logic [7:0] init_val(input int i);
        return 8'(i) ^ 8'h5A;
    endfunction

    function automatic logic [7:0] step_addr(input logic [7:0] a, input int k);
        return a + 8'(k);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic xfer_bit(input logic b, output logic m);
        @(negedge clk);
        sclk = 1'b0;
        mosi = b;
        repeat (HALF) @(negedge clk);
        m = miso_o;
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic xfer_bits(input logic [7:0] b, input int n, output logic [7:0] r);
        logic m;
        r = '0;
        for (int i = 7; i > 7 - n; i--) begin
            xfer_bit(b[i], m);
            r[i] = m;
        end
    endtask

    task automatic xfer_byte(input logic [7:0] b, output logic [7:0] r);
        xfer_bits(b, 8, r);
    endtask

    task automatic frame_open();
        @(negedge clk);
        sel = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic frame_close();
        @(negedge clk);
        sclk = 1'b0;
        repeat (HALF) @(negedge clk);
        sel = 1'b1;
        repeat (3 * HALF) @(negedge clk);
    endtask

    task automatic wr_frame(input logic [7:0] a, input logic [7:0] d [4], input int n);
        logic [7:0] r;
        frame_open();
        xfer_byte(8'hD4, r);
        xfer_byte(a, r);
        for (int k = 0; k < n; k++) begin
            xfer_byte(d[k], r);
            exp_regs[step_addr(a, k)] = d[k];
        end
        frame_close();
    endtask

    task automatic rd_burst(input logic [7:0] a, input int n, input string req);
        logic [7:0] r;
        logic [7:0] none [4];
        wr_frame(a, none, 0);
        frame_open();
        xfer_byte(8'hD5, r);
        for (int k = 0; k < n; k++) begin
            xfer_byte(8'h00, r);
            check(req, r, exp_regs[step_addr(a, k)]);
        end
        frame_close();
    endtask

    initial begin
        logic [7:0] r;
        logic [7:0] d [4];
        logic [7:0] a;
        int n;
        int miso_seen;
        void'($urandom(32'h00C0FFEE));
        for (int i = 0; i < 256; i++) exp_regs[i] = init_val(i);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // reset state
        check("R1 reset mode", spi_mode_o, 0);
        check("R1 reset miso", miso_o, 0);
        check("R1 reset we", rf_we_o, 0);

        // entry pulse 1 carries a would-be write, pulse 2 a would-be read
        frame_open();
        xfer_byte(8'hD4, r);
        xfer_byte(8'h10, r);
        xfer_byte(8'hAA, r);
        frame_close();
        frame_open();
        miso_seen = 0;
        xfer_byte(8'hD5, r);
        miso_seen |= r;
        xfer_byte(8'h00, r);
        miso_seen |= r;
        frame_close();
        check("R1 mode after two pulses", spi_mode_o, 0);
        check("R1 no write before entry", regs[8'h10], exp_regs[8'h10]);
        check("R1 miso low before entry", miso_seen, 0);
        frame_open();
        frame_close();
        check("R1 mode after third pulse", spi_mode_o, 1);

        // single register write, neighbours untouched
        d[0] = 8'h3C;
        wr_frame(8'h80, d, 1);
        check("R4 single write", regs[8'h80], 8'h3C);
        check("R5 neighbour below", regs[8'h7F], exp_regs[8'h7F]);
        check("R5 neighbour above", regs[8'h81], exp_regs[8'h81]);

        // burst across the top of the address space
        d[0] = 8'h01; d[1] = 8'h02; d[2] = 8'h03;
        wr_frame(8'hFE, d, 3);
        check("R5 wrap FE", regs[8'hFE], 8'h01);
        check("R5 wrap FF", regs[8'hFF], 8'h02);
        check("R5 wrap 00", regs[8'h00], 8'h03);
        rd_burst(8'hFD, 4, "R7 read across wrap");

        // partial byte after a complete one
        frame_open();
        xfer_byte(8'hD4, r);
        xfer_byte(8'h40, r);
        xfer_byte(8'h11, r);
        xfer_bits(8'h22, 5, r);
        frame_close();
        exp_regs[8'h40] = 8'h11;
        check("R6 complete byte kept", regs[8'h40], 8'h11);
        check("R6 partial byte dropped", regs[8'h41], exp_regs[8'h41]);

        // frame cut right after the subaddress: no write
        frame_open();
        xfer_byte(8'hD4, r);
        xfer_byte(8'h60, r);
        xfer_bits(8'hFF, 7, r);
        frame_close();
        check("R6 seven bits dropped", regs[8'h60], exp_regs[8'h60]);

        // unknown command
        frame_open();
        xfer_byte(8'h55, r);
        miso_seen = 0;
        xfer_byte(8'h30, r);
        miso_seen |= r;
        xfer_byte(8'h99, r);
        miso_seen |= r;
        frame_close();
        check("R8 no write on bad command", regs[8'h30], exp_regs[8'h30]);
        check("R8 miso low on bad command", miso_seen, 0);
        // a near-miss of the read code also stays inert
        frame_open();
        xfer_byte(8'hD7, r);
        xfer_byte(8'h00, r);
        frame_close();
        check("R8 miso low on D7", r, 0);

        // random write then read-back bursts
        for (int it = 0; it < 20; it++) begin
            a = 8'($urandom);
            n = 1 + int'($urandom % 4);
            for (int k = 0; k < 4; k++) d[k] = 8'($urandom);
            wr_frame(a, d, n);
            rd_burst(a, n, "R3 R4 R7 random burst");
        end

        // whole register file against the model
        miso_seen = 0;
        for (int i = 0; i < 256; i++) if (regs[i] != exp_regs[i]) miso_seen++;
        check("R4 register file matches model", miso_seen, 0);
        check("R2 mode still set", spi_mode_o, 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R3: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule